// File: doc/BRIEF.md
# Power Mode Clock Controller

This block decides which clocks of a small system run and which clock sources sit in standby. It keeps the controller in one of three operating modes. In normal mode the generated main clock drives the chip. In wait mode only the processor core clock is switched off. In slow mode the clock generator is shut down and the whole system runs from the 32.768 kHz slow clock. Independently of the mode, software can gate the DMA-controller clock, put the analog peripherals in standby and start or stop each peripheral clock on its own.

Software drives the block through a small write port: a 2-bit register select and a data word. An interrupt-pending input wakes the core out of wait mode. Two ready inputs from the main oscillator and the PLL tell the controller when it may move back from the slow clock to the main clock. The outputs are level enables and select lines meant for clock-gating and clock-switch cells that sit outside this block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode readback is 00, the core and DMA clock enables are 1, the slow-clock select is 0, no standby output is asserted and every peripheral clock enable is 0.
- R2: A write with select 0 requests a mode from data bits [1:0], and the readback reports the current mode as 00 normal, 01 wait, 10 slow; the code 11 is ignored.
- R3: A write of 01 with select 0 in normal mode clears the core clock enable and shows readback 01 on the next cycle, leaving the DMA enable, the slow-clock select and the standby outputs unchanged.
- R4: In wait mode, a cycle that samples irq_pend high returns the controller to normal mode with the core clock enable set on the next cycle; mode writes made in wait mode are ignored.
- R5: A write of 10 with select 0 in normal mode sets the slow-clock select and readback 10 on the next cycle with standby still low, and asserts oscillator and PLL standby one cycle later.
- R6: A write of 00 with select 0 in slow mode releases oscillator and PLL standby on the next cycle while the slow-clock select stays 1 and readback stays 10; the select drops and readback turns 00 on the cycle after both ready inputs are sampled high. Writes of 01 in slow mode are ignored.
- R7: A write with select 1 sets the peripheral clock enables whose data bits are 1, a write with select 2 clears them; the change appears on the next cycle in every mode.
- R8: A write with select 3 loads the DMA clock enable from data bit 0 and the analog standby from data bit 1, visible on the next cycle in every mode.
- R9: irq_pend has no effect outside wait mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 peripheral set, 2 peripheral clear, 3 DMA/analog control |
| wr_data | input | NUM_PERIPH | Write data |
| irq_pend | input | 1 | Interrupt pending, wakes from wait mode |
| osc_rdy | input | 1 | Main oscillator stable |
| pll_rdy | input | 1 | PLL locked |
| core_clk_en | output | 1 | Processor core clock enable |
| dma_clk_en | output | 1 | DMA-controller clock enable |
| slow_sel | output | 1 | 1 selects the 32.768 kHz clock as system clock |
| osc_stby | output | 1 | Main oscillator standby request |
| pll_stby | output | 1 | PLL standby request |
| ana_stby | output | 1 | Analog peripherals standby request |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| mode_rd | output | 2 | Current mode readback |

## Verification
A wrong mode state shows at the ports within one cycle, because every output is a registered decode of the next state: a stuck wait state keeps the core enable low after irq_pend, and a skipped slow-entry step makes standby rise in the same cycle as the clock select. A broken exit path shows as the select falling before both ready inputs have been seen high, or as readback leaving 10 too early. Peripheral and DMA enables are checked directly one cycle after each write, in each of the three modes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        ST_NORM     = 3'd0,
        ST_WAIT     = 3'd1,
        ST_SLOW_IN  = 3'd2,
        ST_SLOW     = 3'd3,
        ST_SLOW_OUT = 3'd4
    } pmc_state_e;

    localparam logic [1:0] MODE_NORM = 2'b00;
    localparam logic [1:0] MODE_WAIT = 2'b01;
    localparam logic [1:0] MODE_SLOW = 2'b10;

    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_PSET = 2'd1;
    localparam logic [1:0] SEL_PCLR = 2'd2;
    localparam logic [1:0] SEL_MISC = 2'd3;

endpackage

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] req_mode,
    input  logic       irq_pend,
    input  logic       osc_rdy,
    input  logic       pll_rdy,
    output logic       core_clk_en,
    output logic       slow_sel,
    output logic       osc_stby,
    output logic       pll_stby,
    output logic [1:0] mode_code
);

    typedef struct packed {
        pmc_state_e st;
        logic       core;
        logic       slow;
        logic       osc_sb;
        logic       pll_sb;
        logic [1:0] code;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_NORM: begin
                if (mode_wr && req_mode == MODE_WAIT)      s_d.st = ST_WAIT;
                else if (mode_wr && req_mode == MODE_SLOW) s_d.st = ST_SLOW_IN;
            end
            ST_WAIT:     if (irq_pend) s_d.st = ST_NORM;
            ST_SLOW_IN:  s_d.st = ST_SLOW;
            ST_SLOW:     if (mode_wr && req_mode == MODE_NORM) s_d.st = ST_SLOW_OUT;
            ST_SLOW_OUT: if (osc_rdy && pll_rdy) s_d.st = ST_NORM;
            default:     s_d.st = ST_NORM;
        endcase
        // outputs follow the next state so they switch with it
        s_d.core   = (s_d.st != ST_WAIT);
        s_d.slow   = (s_d.st == ST_SLOW_IN) || (s_d.st == ST_SLOW) ||
                     (s_d.st == ST_SLOW_OUT);
        s_d.osc_sb = (s_d.st == ST_SLOW);
        s_d.pll_sb = (s_d.st == ST_SLOW);
        s_d.code   = (s_d.st == ST_WAIT) ? MODE_WAIT :
                     (s_d.slow ? MODE_SLOW : MODE_NORM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_NORM;
            s_q.core   <= 1'b1;
            s_q.slow   <= 1'b0;
            s_q.osc_sb <= 1'b0;
            s_q.pll_sb <= 1'b0;
            s_q.code   <= MODE_NORM;
        end else begin
            s_q <= s_d;
        end
    end

    assign core_clk_en = s_q.core;
    assign slow_sel    = s_q.slow;
    assign osc_stby    = s_q.osc_sb;
    assign pll_stby    = s_q.pll_sb;
    assign mode_code   = s_q.code;

    assert_wait_core_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == MODE_WAIT) |-> !core_clk_en);

    assert_wake_on_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == MODE_WAIT && irq_pend) |=> (core_clk_en && mode_code == MODE_NORM));

    assert_stby_needs_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stby || pll_stby) |-> slow_sel);

    assert_select_before_stby_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_stby) |-> $past(slow_sel));

    assert_main_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slow_sel) |-> $past(osc_rdy && pll_rdy));

    assert_slow_exit_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_stby) |-> (slow_sel && mode_code == MODE_SLOW));

endmodule

// File: rtl/pmc_periph_en.sv
module pmc_periph_en #(
    parameter int NUM_PERIPH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_wr,
    input  logic                  clr_wr,
    input  logic [NUM_PERIPH-1:0] mask,
    output logic [NUM_PERIPH-1:0] en
);

    logic [NUM_PERIPH-1:0] en_d, en_q;

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_bit
        always_comb begin
            en_d[i] = en_q[i];
            if (set_wr && mask[i]) en_d[i] = 1'b1;
            if (clr_wr && mask[i]) en_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en = en_q;

    assert_clear_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((en & $past(mask)) == '0));

    assert_set_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((en & $past(mask)) == $past(mask)));

endmodule

// File: rtl/pmc_misc_reg.sv
module pmc_misc_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] data,
    output logic       dma_en,
    output logic       ana_sb
);

    typedef struct packed {
        logic dma;
        logic ana;
    } misc_t;

    misc_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr) begin
            m_d.dma = data[0];
            m_d.ana = data[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q.dma <= 1'b1;
            m_q.ana <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign dma_en = m_q.dma;
    assign ana_sb = m_q.ana;

    assert_misc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (dma_en == $past(data[0]) && ana_sb == $past(data[1])));

    assert_misc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(dma_en) && $stable(ana_sb)));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NUM_PERIPH = 16   // at least 2: mode and control fields use bits [1:0]
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [NUM_PERIPH-1:0] wr_data,
    input  logic                  irq_pend,
    input  logic                  osc_rdy,
    input  logic                  pll_rdy,
    output logic                  core_clk_en,
    output logic                  dma_clk_en,
    output logic                  slow_sel,
    output logic                  osc_stby,
    output logic                  pll_stby,
    output logic                  ana_stby,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic [1:0]            mode_rd
);

    logic mode_wr, pset_wr, pclr_wr, misc_wr;

    always_comb begin
        mode_wr = wr_en && (wr_sel == SEL_MODE);
        pset_wr = wr_en && (wr_sel == SEL_PSET);
        pclr_wr = wr_en && (wr_sel == SEL_PCLR);
        misc_wr = wr_en && (wr_sel == SEL_MISC);
    end

    pmc_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .req_mode    (wr_data[1:0]),
        .irq_pend    (irq_pend),
        .osc_rdy     (osc_rdy),
        .pll_rdy     (pll_rdy),
        .core_clk_en (core_clk_en),
        .slow_sel    (slow_sel),
        .osc_stby    (osc_stby),
        .pll_stby    (pll_stby),
        .mode_code   (mode_rd)
    );

    pmc_periph_en #(.NUM_PERIPH(NUM_PERIPH)) u_periph (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (pset_wr),
        .clr_wr (pclr_wr),
        .mask   (wr_data),
        .en     (periph_clk_en)
    );

    pmc_misc_reg u_misc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (misc_wr),
        .data   (wr_data[1:0]),
        .dma_en (dma_clk_en),
        .ana_sb (ana_stby)
    );

    assert_irq_outside_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == MODE_NORM && !mode_wr) |=> (mode_rd == MODE_NORM));

    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd != 2'b11);

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [NP-1:0] wr_data = '0;
    logic          irq_pend = 1'b0, osc_rdy = 1'b0, pll_rdy = 1'b0;
    logic          core_clk_en, dma_clk_en, slow_sel, osc_stby, pll_stby, ana_stby;
    logic [NP-1:0] periph_clk_en;
    logic [1:0]    mode_rd;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.NUM_PERIPH(NP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_pend(irq_pend), .osc_rdy(osc_rdy), .pll_rdy(pll_rdy),
        .core_clk_en(core_clk_en), .dma_clk_en(dma_clk_en), .slow_sel(slow_sel),
        .osc_stby(osc_stby), .pll_stby(pll_stby), .ana_stby(ana_stby),
        .periph_clk_en(periph_clk_en), .mode_rd(mode_rd)
    );

    typedef struct packed {
        logic          core;
        logic          dma;
        logic          slow;
        logic          osc;
        logic          pll;
        logic          ana;
        logic [NP-1:0] per;
        logic [1:0]    mode;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    obs_t  cur;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    // monitor: compares one queued expectation per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            obs_t  e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{core_clk_en, dma_clk_en, slow_sel, osc_stby, pll_stby,
                  ana_stby, periph_clk_en, mode_rd};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
        end
    end

    // driver: applies inputs for one cycle and queues the result expected after the edge
    task automatic step(input logic w, input logic [1:0] sel, input logic [NP-1:0] d,
                        input logic irq, input logic ordy, input logic prdy,
                        input string tag);
        wr_en = w; wr_sel = sel; wr_data = d;
        irq_pend = irq; osc_rdy = ordy; pll_rdy = prdy;
        @(posedge clk);
        #1;
        exp_q.push_back(cur);
        tag_q.push_back(tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cur = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 2'b00};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 2'd0, '0, 0, 0, 0, "R1 reset state");

        // R2: code 11 ignored
        step(1, 2'd0, 16'h0003, 0, 0, 0, "R2 code 11 ignored");

        // R7 set / clear in normal mode
        cur.per = 16'h00A5;
        step(1, 2'd1, 16'h00A5, 0, 0, 0, "R7 set in normal");
        cur.per = 16'h00A0;
        step(1, 2'd2, 16'h0005, 0, 0, 0, "R7 clear in normal");

        // R8 control register: bit0 dma, bit1 analog standby
        cur.dma = 1'b0; cur.ana = 1'b1;
        step(1, 2'd3, 16'h0002, 0, 0, 0, "R8 dma off analog standby");
        cur.dma = 1'b1; cur.ana = 1'b0;
        step(1, 2'd3, 16'h0001, 0, 0, 0, "R8 dma on");

        // R9 irq in normal
        step(0, 2'd0, '0, 1, 0, 0, "R9 irq in normal");

        // R3 wait entry
        cur.core = 1'b0; cur.mode = 2'b01;
        step(1, 2'd0, 16'h0001, 0, 0, 0, "R3 enter wait");
        step(1, 2'd0, 16'h0000, 0, 0, 0, "R4 mode write in wait ignored");
        cur.per = 16'h00A1;
        step(1, 2'd1, 16'h0001, 0, 0, 0, "R7 set in wait");
        cur.dma = 1'b0;
        step(1, 2'd3, 16'h0000, 0, 0, 0, "R8 dma off in wait");
        cur.core = 1'b1; cur.mode = 2'b00;
        step(0, 2'd0, '0, 1, 0, 0, "R4 wake on irq");
        cur.dma = 1'b1;
        step(1, 2'd3, 16'h0001, 0, 0, 0, "R8 dma back on");

        // R5 slow entry
        cur.slow = 1'b1; cur.mode = 2'b10;
        step(1, 2'd0, 16'h0002, 0, 1, 1, "R5 select slow first");
        cur.osc = 1'b1; cur.pll = 1'b1;
        step(0, 2'd0, '0, 0, 1, 1, "R5 standby after select");
        step(1, 2'd0, 16'h0001, 0, 0, 0, "R6 wait request in slow ignored");
        step(0, 2'd0, '0, 1, 0, 0, "R9 irq in slow");
        cur.per = 16'h0000;
        step(1, 2'd2, 16'h00A1, 0, 0, 0, "R7 clear in slow");

        // R6 slow exit
        cur.osc = 1'b0; cur.pll = 1'b0;
        step(1, 2'd0, 16'h0000, 0, 0, 0, "R6 release standby");
        step(0, 2'd0, '0, 0, 0, 0, "R6 hold slow no ready");
        step(0, 2'd0, '0, 0, 1, 0, "R6 hold slow osc only");
        step(0, 2'd0, '0, 0, 0, 1, "R6 hold slow pll only");
        cur.slow = 1'b0; cur.mode = 2'b00;
        step(0, 2'd0, '0, 0, 1, 1, "R6 back to main clock");
        step(0, 2'd0, '0, 1, 1, 1, "R9 irq after exit");

        // R2 readback after another full wait cycle
        cur.core = 1'b0; cur.mode = 2'b01;
        step(1, 2'd0, 16'h0001, 0, 1, 1, "R2 readback wait");
        cur.core = 1'b1; cur.mode = 2'b00;
        step(0, 2'd0, '0, 1, 1, 1, "R2 readback normal");

        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule